// File: doc/BRIEF.md
# Oscillator Stabilization Delay Counter

This block is a free-running prescaler chain, stepped on the falling edge of the fast clock (four times the bus rate). It holds the internal bus clocks off until the oscillator has had time to settle. A settling delay is needed in two cases: when power is first applied, and when the chip leaves its low-power stop state. The same chain also divides the fast clock down to make the clock for the watchdog timer.

A power-on request clears the chain at once and starts a long settling delay. A stop request clears the chain and freezes it. A wake event ends the stop state and starts a delay. The wake event can be an interrupt, a break, or a pin reset. The length of a wake delay is set by a short-recovery bit, which the block captures when the wake is seen. A pin reset never clears or alters the chain. When a delay has run out, the chain keeps counting freely. Each wrap of the twelve counting stages toggles a thirteenth stage, and that stage is the watchdog clock.

Top module: `osc_settle_timer`

## Requirements
- R1: While `por_req` is high, the chain is zero and `bus_clk_en`, `rec_done` and `wdog_clk` are low. The chain changes only on falling edges of `clk_x4`.
- R2: After `por_req` is released, `bus_clk_en` rises on the 4096th falling edge, whatever value `short_rec` holds.
- R3: `rec_done` is high for exactly one cycle, on the same edge at which `bus_clk_en` rises.
- R4: `wdog_clk` toggles each time the 12-bit chain wraps from 4095 to 0. Its period is 8192 fast-clock cycles, and its first toggle comes on the edge that ends the power-on delay.
- R5: A `stop_req` sampled while the bus clocks run clears the chain and drops `bus_clk_en` on that edge. Until a wake event arrives, the chain stays frozen and `wdog_clk` does not toggle.
- R6: A wake event (`wake_irq`, `wake_brk` or `ext_rst`) sampled in stop with `short_rec`=1 raises `bus_clk_en` on the 32nd falling edge after the sampling edge.
- R7: The same wake with `short_rec`=0 raises `bus_clk_en` on the 4096th falling edge after the sampling edge.
- R8: `short_rec` is captured on the wake edge. A later change to it does not change the length of the delay already in progress.
- R9: `ext_rst` while the bus clocks run has no effect: `bus_clk_en` stays high and the timing of `wdog_clk` is unchanged.
- R10: The chain starts from zero on the wake edge and runs freely through and past the end of the delay. As a result, the next `wdog_clk` toggle comes 4096 edges after the wake edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_x4 | input | 1 | Fast clock; the chain steps on its falling edge |
| por_req | input | 1 | Power-on reset request, asynchronous, active high |
| stop_req | input | 1 | Stop-entry pulse, sampled on a falling edge |
| wake_irq | input | 1 | Interrupt wake event |
| wake_brk | input | 1 | Break wake event |
| ext_rst | input | 1 | Pin reset; it wakes from stop but never touches the chain |
| short_rec | input | 1 | 1 selects a 32-cycle wake delay, 0 selects a 4096-cycle delay |
| bus_clk_en | output | 1 | High while the bus clocks may run |
| rec_done | output | 1 | One-cycle pulse when a settling delay ends |
| wdog_clk | output | 1 | Thirteenth-stage output that clocks the watchdog |

## Verification
The assertions assume that `por_req` is driven high from time zero and is held across several edges. They also assume that every other input changes only away from the falling edge, so each input has one clear sampled value per edge. The bench drives all inputs on the rising edge and pulses `stop_req` and each wake source for one full cycle. It raises a wake only while the block is in stop and requests a stop only while the bus clocks run. It changes `short_rec` only after the wake edge has captured it.

// File: rtl/osc_settle_pkg.sv
package osc_settle_pkg;
   typedef enum logic [1:0] {
      ST_POR_WAIT  = 2'd0,
      ST_RUN       = 2'd1,
      ST_STOP      = 2'd2,
      ST_WAKE_WAIT = 2'd3
   } settle_state_e;
endpackage

// File: rtl/osc_div_chain.sv
module osc_div_chain #(
   parameter int STAGES = 12
) (
   input  logic              clk_x4,
   input  logic              arst,
   input  logic              clr,
   input  logic              adv,
   output logic [STAGES-1:0] cnt,
   output logic              wrap
);
   logic [STAGES:0] carry;
   assign carry[0] = adv;

   for (genvar gi = 0; gi < STAGES; gi++) begin : g_stage
      logic bit_q;
      always_ff @(negedge clk_x4 or posedge arst) begin
         if (arst)             bit_q <= 1'b0;
         else if (clr)         bit_q <= 1'b0;
         else if (carry[gi])   bit_q <= ~bit_q;
      end
      assign cnt[gi]      = bit_q;
      assign carry[gi+1]  = carry[gi] & bit_q;
   end

   assign wrap = carry[STAGES];

   // R5: a frozen, uncleared chain keeps its value
   p_frozen_hold_r5: assert property (@(negedge clk_x4) disable iff (arst)
      (!adv && !clr) |=> $stable(cnt));
   // R10: an advancing chain steps by one
   p_step_one_r10: assert property (@(negedge clk_x4) disable iff (arst)
      (adv && !clr) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/osc_recovery_ctrl.sv
module osc_recovery_ctrl
   import osc_settle_pkg::*;
#(
   parameter int STAGES       = 12,
   parameter int SHORT_STAGES = 5
) (
   input  logic              clk_x4,
   input  logic              arst,
   input  logic              stop_req,
   input  logic              wake,
   input  logic              short_rec,
   input  logic [STAGES-1:0] cnt,
   output logic              adv,
   output logic              clr,
   output logic              bus_clk_en,
   output logic              rec_done
);
   settle_state_e state_q, state_d;
   logic short_q;
   logic waiting, hit_short, hit_long, expire;

   assign hit_short = &cnt[SHORT_STAGES-1:0];
   assign hit_long  = &cnt;
   assign waiting   = (state_q == ST_POR_WAIT) || (state_q == ST_WAKE_WAIT);
   assign adv       = (state_q != ST_STOP);
   assign clr       = (state_q == ST_RUN) && stop_req;
   assign expire    = waiting && (short_q ? hit_short : hit_long);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_POR_WAIT:  if (expire)   state_d = ST_RUN;
         ST_RUN:       if (stop_req) state_d = ST_STOP;
         ST_STOP:      if (wake)     state_d = ST_WAKE_WAIT;
         ST_WAKE_WAIT: if (expire)   state_d = ST_RUN;
         default:                    state_d = ST_POR_WAIT;
      endcase
   end

   always_ff @(negedge clk_x4 or posedge arst) begin
      if (arst) begin
         state_q  <= ST_POR_WAIT;
         short_q  <= 1'b0;
         rec_done <= 1'b0;
      end else begin
         state_q  <= state_d;
         rec_done <= expire;
         if (state_q == ST_STOP && wake) short_q <= short_rec;
      end
   end

   assign bus_clk_en = (state_q == ST_RUN);

   // R3: the enable only rises together with the done pulse
   p_rise_with_done_r3: assert property (@(negedge clk_x4) disable iff (arst)
      $rose(bus_clk_en) |-> rec_done);
   // R3: the done indication is a single-cycle pulse
   p_done_single_r3: assert property (@(negedge clk_x4) disable iff (arst)
      rec_done |=> !rec_done);
   // R5: a stop clears the chain and drops the enable
   p_stop_clears_r5: assert property (@(negedge clk_x4) disable iff (arst)
      clr |=> (!bus_clk_en && cnt == '0));
endmodule

// File: rtl/osc_wdog_div.sv
module osc_wdog_div (
   input  logic clk_x4,
   input  logic arst,
   input  logic wrap,
   output logic wdog_clk
);
   always_ff @(negedge clk_x4 or posedge arst) begin
      if (arst)      wdog_clk <= 1'b0;
      else if (wrap) wdog_clk <= ~wdog_clk;
   end

   // R4: the watchdog clock moves only on a chain wrap
   p_toggle_on_wrap_r4: assert property (@(negedge clk_x4) disable iff (arst)
      (wdog_clk != $past(wdog_clk)) |-> $past(wrap));
endmodule

// File: rtl/osc_settle_timer.sv
module osc_settle_timer #(
   parameter int CHAIN_STAGES = 12,
   parameter int SHORT_STAGES = 5
) (
   input  logic clk_x4,
   input  logic por_req,
   input  logic stop_req,
   input  logic wake_irq,
   input  logic wake_brk,
   input  logic ext_rst,
   input  logic short_rec,
   output logic bus_clk_en,
   output logic rec_done,
   output logic wdog_clk
);
   localparam int LONG_CYCLES  = 1 << CHAIN_STAGES;
   localparam int SHORT_CYCLES = 1 << SHORT_STAGES;

   if (CHAIN_STAGES < 2 || CHAIN_STAGES > 24) begin : g_bad_chain
      $error("CHAIN_STAGES out of range");
   end
   if (SHORT_STAGES < 1 || SHORT_CYCLES >= LONG_CYCLES) begin : g_bad_short
      $error("SHORT_STAGES must give a delay shorter than the chain");
   end

   logic [CHAIN_STAGES-1:0] cnt;
   logic wrap, adv, clr, wake;

   assign wake = wake_irq | wake_brk | ext_rst;

   osc_div_chain #(.STAGES(CHAIN_STAGES)) u_chain (
      .clk_x4 (clk_x4),
      .arst   (por_req),
      .clr    (clr),
      .adv    (adv),
      .cnt    (cnt),
      .wrap   (wrap)
   );

   osc_recovery_ctrl #(.STAGES(CHAIN_STAGES), .SHORT_STAGES(SHORT_STAGES)) u_ctrl (
      .clk_x4     (clk_x4),
      .arst       (por_req),
      .stop_req   (stop_req),
      .wake       (wake),
      .short_rec  (short_rec),
      .cnt        (cnt),
      .adv        (adv),
      .clr        (clr),
      .bus_clk_en (bus_clk_en),
      .rec_done   (rec_done)
   );

   osc_wdog_div u_wdog (
      .clk_x4   (clk_x4),
      .arst     (por_req),
      .wrap     (wrap),
      .wdog_clk (wdog_clk)
   );

   // R9: a pin reset while running leaves the enable high
   p_ext_rst_quiet_r9: assert property (@(negedge clk_x4) disable iff (por_req)
      (ext_rst && bus_clk_en && !stop_req) |=> bus_clk_en);
endmodule

// File: tb/tb_osc_settle_timer.sv
module tb_osc_settle_timer;
   logic clk = 1'b0;
   logic por_req = 1'b1, stop_req = 1'b0, wake_irq = 1'b0, wake_brk = 1'b0;
   logic ext_rst = 1'b0, short_rec = 1'b1;
   logic bus_clk_en, rec_done, wdog_clk;
   int ne = 0, n_chk = 0, n_fail = 0;
   bit done_flag = 0;

   always #10 clk = ~clk;
   always @(negedge clk) ne++;

   osc_settle_timer dut (
      .clk_x4(clk), .por_req(por_req), .stop_req(stop_req), .wake_irq(wake_irq),
      .wake_brk(wake_brk), .ext_rst(ext_rst), .short_rec(short_rec),
      .bus_clk_en(bus_clk_en), .rec_done(rec_done), .wdog_clk(wdog_clk));

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_bus(output int at);
      at = -1;
      for (int i = 0; i < 10000; i++) begin
         @(posedge clk);
         if (bus_clk_en) begin at = ne; break; end
      end
   endtask

   task automatic wait_wdog(output int at);
      logic prev;
      prev = wdog_clk;
      at = -1;
      for (int i = 0; i < 10000; i++) begin
         @(posedge clk);
         if (wdog_clk != prev) begin at = ne; break; end
      end
   endtask

   task automatic do_stop();
      @(posedge clk); stop_req = 1'b1;
      @(posedge clk); stop_req = 1'b0;
      check(bus_clk_en == 1'b0, "R5 stop drops enable", bus_clk_en, 0);
   endtask

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      int n0, at, tw;
      logic w0;
      repeat (3) @(posedge clk);
      check(bus_clk_en == 0, "R1 reset enable", bus_clk_en, 0);
      check(rec_done == 0, "R1 reset done", rec_done, 0);
      check(wdog_clk == 0, "R1 reset wdog", wdog_clk, 0);
      n0 = ne; por_req = 1'b0;          // short_rec=1 must not shorten power-on
      wait_bus(at);
      check(at == n0 + 4096, "R2 power-on delay", at - n0, 4096);
      check(rec_done == 1, "R3 done with enable", rec_done, 1);
      check(wdog_clk == 1, "R4 first wdog toggle", wdog_clk, 1);
      @(posedge clk);
      check(rec_done == 0, "R3 done single pulse", rec_done, 0);
      repeat (100) @(posedge clk);
      ext_rst = 1'b1; @(posedge clk); ext_rst = 1'b0;
      @(posedge clk);
      check(bus_clk_en == 1, "R9 ext_rst keeps enable", bus_clk_en, 1);
      wait_wdog(tw);
      check(tw == n0 + 8192, "R9 R4 wdog half period", tw - n0, 8192);

      do_stop();
      w0 = wdog_clk;
      repeat (5000) @(posedge clk);
      check(wdog_clk == w0, "R5 wdog frozen in stop", wdog_clk, w0);
      check(bus_clk_en == 0, "R5 enable held low", bus_clk_en, 0);

      short_rec = 1'b1;
      n0 = ne; wake_irq = 1'b1;
      @(posedge clk); wake_irq = 1'b0; short_rec = 1'b0;
      wait_bus(at);
      check(at == n0 + 1 + 32, "R6 R8 short wake by irq", at - n0 - 1, 32);
      check(rec_done == 1, "R3 done on short wake", rec_done, 1);
      wait_wdog(tw);
      check(tw == n0 + 1 + 4096, "R10 free run after wake", tw - n0 - 1, 4096);

      do_stop();
      short_rec = 1'b0;
      w0 = wdog_clk;
      n0 = ne; wake_brk = 1'b1;
      @(posedge clk); wake_brk = 1'b0; short_rec = 1'b1;
      wait_bus(at);
      check(at == n0 + 1 + 4096, "R7 R8 long wake by brk", at - n0 - 1, 4096);
      check(wdog_clk != w0, "R10 wrap at long wake end", wdog_clk, !w0);

      do_stop();
      short_rec = 1'b1;
      n0 = ne; ext_rst = 1'b1;
      @(posedge clk); ext_rst = 1'b0;
      wait_bus(at);
      check(at == n0 + 1 + 32, "R6 short wake by ext_rst", at - n0 - 1, 32);
      finish_run();
   end

   initial begin
      repeat (200000) @(posedge clk);
      check(1'b0, "watchdog expired", 0, 1);
      finish_run();
   end
endmodule